// File: doc/BRIEF.md
# Serial Gain Code Endpoint

This block sits at the far end of a slow serial link, one instance per amplifier channel. It keeps a single channel's 4-bit gain code and drives it on a gain-select output toward the amplifier. A controller raises the select enable of one endpoint and sends a frame. The first bit names the direction. A write frame then carries the new code, most significant bit first. A read frame makes the endpoint shift its stored code back out on the serial return line. A broadcast clear strobe, shared by all endpoints, forces the stored code to the minimum gain.

Gain codes step the amplifier by 2:1. Code 0 is the lowest gain (x0.25) and code 8 is the highest (x64). A code above 8 is clamped to 8 when it is stored, so a later readback also returns 8. The select enable works as the channel's clock gate: while it is low the endpoint takes no serial data, and its output does not move. The stored code is not initialised by the framing reset. It stays undefined until the first write or broadcast clear.

Top module: `gain_endpoint`

## Requirements
- R1: A write frame is `sel` high with direction bit `sdi`=0, then four code bits MSB first on the next four edges. `gain` takes the received code after the edge that samples the fourth bit.
- R2: While bits 1 to 3 of a write frame are shifting in, `gain` keeps its previous value.
- R3: A received code above 8 is stored as 8. Codes 0 to 8 are stored unchanged.
- R4: A read frame is `sel` high with direction bit `sdi`=1. After each of the next four edges, `sdo` shows the stored code, MSB first. At all other times `sdo` is 0.
- R5: A read frame leaves `gain` unchanged, and a clamped code reads back as 8.
- R6: With `clr` high at an edge, `gain` becomes 0 after that edge, whatever the state of `sel`. This holds even when a write completes on the same edge.
- R7: While `sel` is low and `clr` is low, `gain` does not change, `sdi` is ignored and `sdo` stays 0.
- R8: Dropping `sel` part way through a frame discards the partial frame. The next frame starts again with a direction bit.
- R9: After a frame has finished, further bits received while `sel` stays high are ignored until `sel` falls.
- R10: With `rst_n` low at an edge, the framing returns to idle and `sdo` becomes 0. `gain` is left untouched by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock. Only edges with `sel` high act on the frame. |
| rst_n | input | 1 | Synchronous active-low framing reset |
| sel | input | 1 | Channel select; acts as the clock enable and delimits a frame |
| sdi | input | 1 | Serial data from the controller |
| clr | input | 1 | Broadcast clear strobe; sets the gain code to 0 |
| sdo | output | 1 | Serial readback data toward the controller |
| gain | output | 4 | Stored gain code driven to the amplifier (0 to 8) |

## Verification
The assertions assume that `clr` and `sel` are clean levels sampled at the rising edge. They also assume that the stored code is only judged once a write or clear has defined it. The gain-stability properties therefore only speak about cycles after a defined update, and the bench issues a broadcast clear before any check of `gain`. All stimulus changes on the falling edge, and every frame is framed by a full `sel` pulse, except in the deliberate abort and overrun cases.

// File: rtl/gain_ep_pkg.sv
// Shared types for the serial gain endpoint.
// Assumes: one frame per select pulse, direction bit first.
package gain_ep_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting for direction bit
        PH_WR   = 2'd1,   // receiving code bits
        PH_RD   = 2'd2,   // sending code bits
        PH_DONE = 2'd3    // frame over, ignore until select drops
    } frame_ph_t;
endpackage

// File: rtl/ep_frame_ctl.sv
// Frame sequencer: decodes the direction bit and counts the code bits.
// Assumes sel is high for a whole frame; a low sel aborts and rearms.
module ep_frame_ctl
    import gain_ep_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sdi,
    output logic load_rd,
    output logic shift_rd,
    output logic shift_wr,
    output logic commit
);
    localparam int CNT_W = (CODE_W > 2) ? $clog2(CODE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

    frame_ph_t        ph;
    logic [CNT_W-1:0] cnt;

    // Phase and bit counter; cleared whenever the channel is deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    ph  <= sdi ? PH_RD : PH_WR;
                    cnt <= '0;
                end
                PH_WR, PH_RD: begin
                    if (cnt == LAST) begin
                        ph  <= PH_DONE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_DONE;
            endcase
        end
    end

    // Per-edge strobes to the data path.
    always_comb begin
        load_rd  = rst_n && sel && (ph == PH_IDLE) && sdi;
        shift_wr = rst_n && sel && (ph == PH_WR);
        shift_rd = rst_n && sel && (ph == PH_RD);
        commit   = shift_wr && (cnt == LAST);
    end

    // Framing returns to idle after a deselected edge (R8).
    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (ph == PH_IDLE && cnt == '0));

    // At most one data-path action per edge; none after the frame ends (R9).
    p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_rd, shift_rd, shift_wr}));

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_DONE) |-> !(shift_wr || shift_rd || load_rd));
endmodule

// File: rtl/ep_gain_reg.sv
// Gain store: assembles the code bits and clamps them on commit.
// Assumes commit arrives on the edge that samples the last code bit.
// The code has no reset value; only clr or a write defines it.
module ep_gain_reg #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic              shift_wr,
    input  logic              commit,
    input  logic              clr,
    output logic [CODE_W-1:0] gain
);
    localparam logic [CODE_W-1:0] TOP = CODE_W'(MAX_CODE);

    logic [CODE_W-2:0] wr_sh;
    logic [CODE_W-1:0] word;

    function automatic logic [CODE_W-1:0] clamp(input logic [CODE_W-1:0] c);
        return (c > TOP) ? TOP : c;
    endfunction

    assign word = {wr_sh, sdi};

    // Collect the leading code bits, MSB first.
    always_ff @(posedge clk) begin
        if (shift_wr) wr_sh <= word[CODE_W-2:0];
    end

    // Update the code only on a whole frame or a broadcast clear.
    always_ff @(posedge clk) begin
        if (clr)         gain <= '0;
        else if (commit) gain <= clamp(word);
    end

    // R3: a committed code is always legal.
    p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !clr) |=> (gain <= TOP));

    // R6: a broadcast clear wins and yields the minimum.
    p_clear_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (gain == '0));

    // R2: no change to the gain between commits.
    p_no_partial_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !clr) |=> $stable(gain));
endmodule

// File: rtl/ep_readback.sv
// Readback shifter: captures the code at the direction bit, then
// presents it MSB first, one bit per read edge. Idle level is 0.
module ep_readback #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_rd,
    input  logic              shift_rd,
    input  logic [CODE_W-1:0] gain,
    output logic              sdo
);
    logic [CODE_W-1:0] sh;

    // Snapshot and shift the outgoing code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            sdo <= 1'b0;
        end else begin
            if (load_rd)       sh <= gain;
            else if (shift_rd) sh <= sh << 1;
            sdo <= shift_rd ? sh[CODE_W-1] : 1'b0;
        end
    end

    // R4: the line is only driven high on a read edge.
    p_sdo_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_rd |=> !sdo);
endmodule

// File: rtl/gain_endpoint.sv
// Per-channel serial gain endpoint: write frames set the code,
// read frames return it, clr forces the minimum gain.
// Assumes sel gates all activity; nothing moves while it is low.
module gain_endpoint #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sdi,
    input  logic              clr,
    output logic              sdo,
    output logic [CODE_W-1:0] gain
);
    logic load_rd, shift_rd, shift_wr, commit;

    ep_frame_ctl #(.CODE_W(CODE_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sdi(sdi),
        .load_rd(load_rd), .shift_rd(shift_rd),
        .shift_wr(shift_wr), .commit(commit)
    );

    ep_gain_reg #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_gain (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .shift_wr(shift_wr),
        .commit(commit), .clr(clr), .gain(gain)
    );

    ep_readback #(.CODE_W(CODE_W)) u_rb (
        .clk(clk), .rst_n(rst_n), .load_rd(load_rd),
        .shift_rd(shift_rd), .gain(gain), .sdo(sdo)
    );

    // R7: deselected and no clear means the output holds.
    p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !clr) |=> $stable(gain));

    // R7: the return line is quiet after a deselected edge.
    p_idle_sdo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !sdo);
endmodule

// File: tb/tb_gain_endpoint.sv
// Directed bench for gain_endpoint; one task per scenario.
module tb_gain_endpoint;
    logic       clk = 1'b0;
    logic       rst_n, sel, sdi, clr;
    logic       sdo;
    logic [3:0] gain;
    logic [3:0] model;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    gain_endpoint dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sdi(sdi),
        .clr(clr), .sdo(sdo), .gain(gain)
    );

    function automatic logic [3:0] clampc(input logic [3:0] c);
        return (c > 4'd8) ? 4'd8 : c;
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Broadcast clear with the channel deselected (R6).
    task automatic t_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model = 4'd0;
        chk("R6 clear", gain, model);
    endtask

    // Full write frame; checks no partial update (R2) and final value (R1/R3).
    task automatic t_write(input logic [3:0] code, input bit clr_at_end);
        @(negedge clk); sel = 1'b1; sdi = 1'b0;
        for (int i = 3; i >= 0; i--) begin
            @(negedge clk);
            sdi = code[i];
            if (i == 0 && clr_at_end) clr = 1'b1;
            if (i < 3) chk("R2 partial", gain, model);
        end
        @(negedge clk); sel = 1'b0; sdi = 1'b0; clr = 1'b0;
        model = clr_at_end ? 4'd0 : clampc(code);
        if (clr_at_end)      chk("R6 clear beats commit", gain, model);
        else if (code > 8)   chk("R3 clamp", gain, model);
        else                 chk("R1 write", gain, model);
    endtask

    // Full read frame; checks serial bits (R4) and unchanged gain (R5).
    task automatic t_read();
        @(negedge clk); sel = 1'b1; sdi = 1'b1;
        @(negedge clk); sdi = 1'b0;
        chk("R4 before bits", {3'b0, sdo}, 4'd0);
        for (int i = 3; i >= 0; i--) begin
            @(negedge clk);
            chk("R4 read bit", {3'b0, sdo}, {3'b0, model[i]});
        end
        @(negedge clk);
        chk("R4 after bits", {3'b0, sdo}, 4'd0);
        sel = 1'b0;
        chk("R5 read keeps gain", gain, model);
    endtask

    // Deselected noise on sdi (R7).
    task automatic t_idle_noise();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            sdi = i[0] ^ i[1];
            if (i > 0) begin
                chk("R7 gain held", gain, model);
                chk("R7 sdo quiet", {3'b0, sdo}, 4'd0);
            end
        end
        sdi = 1'b0;
    endtask

    // Aborted write, then a read must start on a fresh direction bit (R8).
    task automatic t_abort();
        @(negedge clk); sel = 1'b1; sdi = 1'b0;
        @(negedge clk); sdi = 1'b1;
        @(negedge clk); sdi = 1'b1;
        @(negedge clk); sel = 1'b0; sdi = 1'b0;
        @(negedge clk);
        chk("R8 abort keeps gain", gain, model);
        t_read();
        t_write(4'd2, 1'b0);
        chk("R8 write after abort", gain, 4'd2);
    endtask

    // Bits after a finished frame are ignored while sel stays high (R9).
    task automatic t_overrun();
        logic [4:0] extra;
        extra = 5'b01111;
        @(negedge clk); sel = 1'b1; sdi = 1'b0;
        for (int i = 3; i >= 0; i--) begin
            @(negedge clk); sdi = (4'd6 >> i) & 1'b1;
        end
        for (int i = 4; i >= 0; i--) begin
            @(negedge clk); sdi = extra[i];
        end
        @(negedge clk);
        sdi = 1'b1;
        model = 4'd6;
        chk("R9 extra bits ignored", gain, model);
        chk("R9 no readback", {3'b0, sdo}, 4'd0);
        @(negedge clk);
        chk("R9 direction ignored", {3'b0, sdo}, 4'd0);
        @(negedge clk);
        chk("R9 still no sdo", {3'b0, sdo}, 4'd0);
        sel = 1'b0; sdi = 1'b0;
    endtask

    // Framing reset mid read frame leaves gain alone (R10).
    task automatic t_rst_mid();
        @(negedge clk); sel = 1'b1; sdi = 1'b1;
        @(negedge clk); sdi = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 sdo reset", {3'b0, sdo}, 4'd0);
        chk("R10 gain untouched", gain, model);
        rst_n = 1'b1; sel = 1'b0;
        @(negedge clk);
        t_read();
    endtask

    initial begin
        rst_n = 1'b0; sel = 1'b0; sdi = 1'b0; clr = 1'b0; model = 4'd0;
        repeat (3) @(negedge clk);
        chk("R10 reset sdo", {3'b0, sdo}, 4'd0);
        rst_n = 1'b1;
        t_clear();
        t_read();
        t_write(4'd5, 1'b0);
        t_read();
        t_write(4'd8, 1'b0);
        t_read();
        t_write(4'd0, 1'b0);
        t_write(4'd12, 1'b0);
        t_read();
        t_write(4'd15, 1'b0);
        t_read();
        t_write(4'd3, 1'b0);
        t_idle_noise();
        t_write(4'd7, 1'b1);
        t_write(4'd9, 1'b0);
        t_abort();
        t_overrun();
        t_rst_mid();
        t_write(4'd4, 1'b0);
        t_read();
        t_clear();
        t_read();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule